// File: doc/BRIEF.md
# Window Watchdog with Mode Sequencer

This block supervises a host through a single combined control write. Each write carries a 3-bit operating-mode code and a 4-bit period code, and it also serves as the watchdog trigger. The block counts ticks from a free-running tick strobe against the loaded period. It accepts a trigger only in the second half of that period. A good trigger reloads the timer and may change the period and the operating mode.

Any of the following raises a one-cycle reset request and a 4-bit code naming the cause: a trigger that comes too early, a missed period, a write with an undefined code, or a completed flash-entry sequence. The flash-entry sequence is three good writes in Normal mode carrying modes 111, 001 and 111. After any reset event the block returns to Start-up mode with the longest period.

Mode codes: 001 flash-sequence step (the mode is left unchanged), 010 Sleep, 011 Standby with watchdog off, 100 Standby, 101 Start-up, 111 Normal. Codes 000 and 110 are undefined.

Top module: `wdog_mode_seq`

## Requirements
- R1: While rst_ni is low and after it is released, mode_o is 101 (Start-up), rst_src_o is 0000 and rst_req_o is 0.
- R2: Period code c (0..9) with prescale select p (0..3) gives a period of BASE_TICKS << (c + p) ticks. p is sampled when the period is loaded.
- R3: Outside Start-up mode, a write with valid codes that arrives while the tick count is below half the period causes a reset with source 0100.
- R4: If no good trigger arrives, the tick that completes the period causes a reset with source 0011.
- R5: A good trigger in the window [half, period-1] restarts the count at zero, loads the new period and sets mode_o to the written mode, unless that mode is 001.
- R6: A write with a period code of 10 to 15 and a defined mode code causes a reset with source 0101.
- R7: A write with mode code 000 or 110 causes a reset with source 0111, whatever its period code.
- R8: In Normal mode, three consecutive good triggers with modes 111, 001, 111 cause a reset with source 0110.
- R9: Any good trigger that breaks the flash sequence restarts detection. A 111 write in Normal mode counts as a new first step.
- R10: A good trigger selecting mode 011 loads the longest period (code 9 with the current prescale), whatever its period code.
- R11: In Start-up mode, a write with valid codes is accepted at any tick count, with no early check.
- R12: A good trigger in the same cycle as the tick that would expire the period wins, and no timeout reset occurs.
- R13: On every reset event, rst_req_o is high for one cycle, mode_o returns to 101 and the longest period is loaded. rst_src_o then holds its value until the next reset event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Free-running timebase strobe, one tick per high cycle |
| prescale_i | input | 2 | Period scale select, factor 1, 2, 4 or 8 |
| wr_i | input | 1 | Control-register write strobe, also the watchdog trigger |
| wr_mode_i | input | 3 | Operating-mode code carried by the write |
| wr_period_i | input | 4 | Period code carried by the write |
| rst_req_o | output | 1 | One-cycle system reset request |
| rst_src_o | output | 4 | Cause of the last reset event |
| mode_o | output | 3 | Current operating mode |

## Verification
A trigger write and the tick that completes the period can fall in the same cycle. To provoke this, the bench keeps the tick high every cycle and places a write at count period-1. It then judges that rst_req_o stays low, and that a full new period must pass before any timeout. A write with an undefined code can also coincide with expiry. Code validation takes priority over the window check and over the timeout, and the bench observes this as the code-specific source value.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
  localparam logic [2:0] MODE_FLASH    = 3'b001;
  localparam logic [2:0] MODE_SLEEP    = 3'b010;
  localparam logic [2:0] MODE_STBY_OFF = 3'b011;
  localparam logic [2:0] MODE_STBY     = 3'b100;
  localparam logic [2:0] MODE_START    = 3'b101;
  localparam logic [2:0] MODE_NORMAL   = 3'b111;

  localparam logic [3:0] SRC_POWER    = 4'b0000;
  localparam logic [3:0] SRC_TIMEOUT  = 4'b0011;
  localparam logic [3:0] SRC_EARLY    = 4'b0100;
  localparam logic [3:0] SRC_BAD_PER  = 4'b0101;
  localparam logic [3:0] SRC_FLASH    = 4'b0110;
  localparam logic [3:0] SRC_BAD_MODE = 4'b0111;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GOT1 = 2'd1,
    SEQ_GOT2 = 2'd2
  } seq_e;

  function automatic logic mode_defined(input logic [2:0] m);
    return (m != 3'b000) && (m != 3'b110);
  endfunction
endpackage

// File: rtl/wdm_decode.sv
module wdm_decode #(
  parameter int BASE_TICKS = 4,
  parameter int NUM_CODES  = 10,
  parameter int CNT_W      = 15
) (
  input  logic [2:0]       mode_i,
  input  logic [3:0]       period_i,
  input  logic [1:0]       prescale_i,
  output logic             mode_ok_o,
  output logic             period_ok_o,
  output logic [CNT_W-1:0] ticks_o,
  output logic [CNT_W-1:0] longest_o
);
  import wdm_pkg::*;

  localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE_TICKS);
  localparam logic [4:0]       TOP_CODE = 5'(NUM_CODES - 1);

  logic [4:0] shamt;
  logic [4:0] shamt_max;

  assign mode_ok_o   = mode_defined(mode_i);
  assign period_ok_o = ({1'b0, period_i} < 5'(NUM_CODES));
  assign shamt       = {1'b0, period_i} + {3'b000, prescale_i};
  assign shamt_max   = TOP_CODE + {3'b000, prescale_i};
  assign ticks_o     = BASE_V << shamt;
  assign longest_o   = BASE_V << shamt_max;
endmodule

// File: rtl/wdm_timer.sv
module wdm_timer #(
  parameter int CNT_W     = 15,
  parameter int RST_TICKS = 2048
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_ticks_i,
  output logic             early_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      period_q <= CNT_W'(RST_TICKS);
    end else if (load_i) begin
      cnt_q    <= '0;
      period_q <= load_ticks_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // window opens at half the loaded period
  assign early_o  = cnt_q < (period_q >> 1);
  assign expire_o = tick_i && (cnt_q == period_q - 1'b1);

  AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < period_q); // R4
  AST_EXPIRE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> cnt_q == '0); // R13
endmodule

// File: rtl/wdm_flash_seq.sv
module wdm_flash_seq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       good_i,
  input  logic [2:0] mode_i,
  input  logic       in_normal_i,
  output logic       done_o
);
  import wdm_pkg::*;

  seq_e step_q, step_d;
  logic first_hit;

  assign first_hit = (mode_i == MODE_NORMAL) && in_normal_i;
  assign done_o    = good_i && (step_q == SEQ_GOT2) && (mode_i == MODE_NORMAL);

  always_comb begin
    step_d = step_q;
    if (good_i) begin
      unique case (step_q)
        SEQ_GOT1: step_d = (mode_i == MODE_FLASH) ? SEQ_GOT2 :
                           (first_hit ? SEQ_GOT1 : SEQ_IDLE);
        SEQ_GOT2: step_d = SEQ_IDLE;
        default:  step_d = first_hit ? SEQ_GOT1 : SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      step_q <= SEQ_IDLE;
    else if (clear_i) step_q <= SEQ_IDLE;
    else              step_q <= step_d;
  end

  AST_SEQ_IN_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q != SEQ_IDLE |-> in_normal_i); // R8
endmodule

// File: rtl/wdog_mode_seq.sv
module wdog_mode_seq #(
  parameter int BASE_TICKS = 4,
  parameter int NUM_CODES  = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] prescale_i,
  input  logic       wr_i,
  input  logic [2:0] wr_mode_i,
  input  logic [3:0] wr_period_i,
  output logic       rst_req_o,
  output logic [3:0] rst_src_o,
  output logic [2:0] mode_o
);
  import wdm_pkg::*;

  localparam int MAX_TICKS = BASE_TICKS << (NUM_CODES - 1 + 3);
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam int RST_TICKS = BASE_TICKS << (NUM_CODES - 1);

  logic             mode_ok, period_ok;
  logic [CNT_W-1:0] code_ticks, longest_ticks, load_ticks;
  logic             early, expire, flash_done;
  logic             bad_mode, bad_per, valid_wr, early_hit, good, timeout, event_hit;
  logic [3:0]       src_d;
  logic [2:0]       mode_q;
  logic [3:0]       src_q;
  logic             req_q;

  wdm_decode #(.BASE_TICKS(BASE_TICKS), .NUM_CODES(NUM_CODES), .CNT_W(CNT_W)) u_decode (
    .mode_i     (wr_mode_i),
    .period_i   (wr_period_i),
    .prescale_i (prescale_i),
    .mode_ok_o  (mode_ok),
    .period_ok_o(period_ok),
    .ticks_o    (code_ticks),
    .longest_o  (longest_ticks)
  );

  assign bad_mode  = wr_i && !mode_ok;
  assign bad_per   = wr_i && mode_ok && !period_ok;
  assign valid_wr  = wr_i && mode_ok && period_ok;
  assign early_hit = valid_wr && (mode_q != MODE_START) && early;
  assign good      = valid_wr && !early_hit;
  assign timeout   = expire && !good;
  assign event_hit = bad_mode || bad_per || early_hit || flash_done || timeout;

  always_comb begin
    if (bad_mode)       src_d = SRC_BAD_MODE;
    else if (bad_per)   src_d = SRC_BAD_PER;
    else if (early_hit) src_d = SRC_EARLY;
    else if (flash_done) src_d = SRC_FLASH;
    else                src_d = SRC_TIMEOUT;
  end

  assign load_ticks = (event_hit || wr_mode_i == MODE_STBY_OFF) ? longest_ticks : code_ticks;

  wdm_timer #(.CNT_W(CNT_W), .RST_TICKS(RST_TICKS)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .load_i      (event_hit || good),
    .load_ticks_i(load_ticks),
    .early_o     (early),
    .expire_o    (expire)
  );

  wdm_flash_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (event_hit),
    .good_i     (good),
    .mode_i     (wr_mode_i),
    .in_normal_i(mode_q == MODE_NORMAL),
    .done_o     (flash_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_START;
      src_q  <= SRC_POWER;
      req_q  <= 1'b0;
    end else begin
      req_q <= event_hit;
      if (event_hit) begin
        mode_q <= MODE_START;
        src_q  <= src_d;
      end else if (good && wr_mode_i != MODE_FLASH) begin
        mode_q <= wr_mode_i;
      end
    end
  end

  assign rst_req_o = req_q;
  assign rst_src_o = src_q;
  assign mode_o    = mode_q;

  AST_RST_TO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> mode_o == MODE_START); // R13
  AST_SRC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_req_o |-> $stable(rst_src_o)); // R13
  AST_FLASH_FROM_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && rst_src_o == SRC_FLASH) |-> $past(mode_o) == MODE_NORMAL); // R8
  AST_BAD_MODE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && rst_src_o == SRC_BAD_MODE) |-> $past(wr_i)); // R7
endmodule

// File: tb/test_wdog_mode_seq.sv
module test_wdog_mode_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [1:0] presc = 2'd0;
  logic       wr = 1'b0;
  logic [2:0] wmode = 3'd0;
  logic [3:0] wper = 4'd0;
  logic       req;
  logic [3:0] src;
  logic [2:0] mode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_mode_seq i_wdog_mode_seq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .prescale_i(presc),
    .wr_i(wr), .wr_mode_i(wmode), .wr_period_i(wper),
    .rst_req_o(req), .rst_src_o(src), .mode_o(mode)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req_tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [2:0] m, input logic [3:0] p);
    wr = 1'b1; wmode = m; wper = p;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic ev(input string t, input int s);
    chk({t, " req"}, int'(req), 1);
    chk({t, " src"}, int'(src), s);
    chk({t, " mode"}, int'(mode), 3'b101);
  endtask

  task automatic t_reset;
    idle(3);
    chk("R1 req", int'(req), 0);
    chk("R1 src", int'(src), 0);
    chk("R1 mode", int'(mode), 3'b101);
    rst_n = 1'b1;
    idle(1);
    chk("R1 mode after release", int'(mode), 3'b101);
  endtask

  task automatic t_startup_and_window;
    write(3'b111, 4'd0);            // R11: accepted at count 1
    chk("R11 req", int'(req), 0);
    chk("R5 mode", int'(mode), 3'b111);
    idle(2); write(3'b100, 4'd0);   // R5: window lower edge
    chk("R5 req", int'(req), 0);
    chk("R5 mode standby", int'(mode), 3'b100);
    idle(3); write(3'b111, 4'd0);   // R12: coincides with expiring tick
    chk("R12 req", int'(req), 0);
    idle(3);
    chk("R12 restarted", int'(req), 0);
    write(3'b111, 4'd0);
    chk("R12 second", int'(req), 0);
  endtask

  task automatic t_early;
    idle(1); write(3'b111, 4'd0);
    ev("R3", 4'b0100);
  endtask

  task automatic t_timeout;
    write(3'b111, 4'd0);
    idle(3);
    chk("R4 before", int'(req), 0);
    idle(1);
    ev("R4", 4'b0011);
    idle(3);
    chk("R13 one-cycle", int'(req), 0);
    chk("R13 src held", int'(src), 4'b0011);
  endtask

  task automatic t_prescale;
    presc = 2'd1;
    write(3'b111, 4'd1);            // 4 << 2 = 16 ticks
    idle(15);
    chk("R2 before", int'(req), 0);
    idle(1);
    ev("R2 timeout", 4'b0011);
    write(3'b111, 4'd1);
    idle(7); write(3'b111, 4'd1);   // count 7 < 8
    ev("R2 early", 4'b0100);
    presc = 2'd0;
  endtask

  task automatic t_illegal;
    write(3'b111, 4'd0);
    idle(2); write(3'b111, 4'd12);
    ev("R6", 4'b0101);
    write(3'b110, 4'd12);
    ev("R7 both bad", 4'b0111);
    idle(2); write(3'b000, 4'd0);
    ev("R7", 4'b0111);
  endtask

  task automatic t_flash;
    write(3'b111, 4'd0);
    idle(2); write(3'b111, 4'd0);
    idle(2); write(3'b001, 4'd0);
    chk("R8 mid req", int'(req), 0);
    chk("R8 mid mode", int'(mode), 3'b111);
    idle(2); write(3'b111, 4'd0);
    ev("R8", 4'b0110);
  endtask

  task automatic t_seq_break;
    write(3'b111, 4'd0);
    idle(2); write(3'b111, 4'd0);
    idle(2); write(3'b111, 4'd0);   // restarts as first step
    idle(2); write(3'b001, 4'd0);
    idle(2); write(3'b111, 4'd0);
    ev("R9 restart", 4'b0110);
    write(3'b111, 4'd0);
    idle(2); write(3'b111, 4'd0);
    idle(2); write(3'b001, 4'd0);
    idle(2); write(3'b100, 4'd0);
    chk("R9 break req", int'(req), 0);
    chk("R9 break mode", int'(mode), 3'b100);
    idle(2); write(3'b111, 4'd0);
    idle(2); write(3'b001, 4'd0);
    idle(2); write(3'b111, 4'd0);
    chk("R9 no flash req", int'(req), 0);
    chk("R9 no flash mode", int'(mode), 3'b111);
  endtask

  task automatic t_wdoff;
    idle(2); write(3'b011, 4'd0);
    idle(10);
    chk("R10 req", int'(req), 0);
    chk("R10 mode", int'(mode), 3'b011);
    idle(90); write(3'b111, 4'd0);  // count 100 < 1024
    ev("R10 long period", 4'b0100);
  endtask

  task automatic t_longest_after_event;
    idle(2047);
    chk("R13 longest before", int'(req), 0);
    idle(1);
    ev("R13 longest", 4'b0011);
  endtask

  initial begin
    t_reset();
    t_startup_and_window();
    t_early();
    t_timeout();
    t_prescale();
    t_illegal();
    t_flash();
    t_seq_break();
    t_wdoff();
    t_longest_after_event();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule